// File: doc/BRIEF.md
# Byte-wide USB FIFO bridge

This block lets on-chip logic exchange bytes with a host computer through an external USB FIFO device. The device sits on an 8-bit data bus that carries traffic in both directions. It reports buffer state on two active-low flags: one says there is room to accept a byte, the other says a received byte is waiting. The bridge turns a valid/ready input stream into write cycles on that bus, and turns read cycles into a valid/ready output stream.

A single sequencer owns the shared bus and runs one transfer at a time. A write drives the byte and sets the output enable one cycle before the write strobe rises. It keeps the byte on the bus for one cycle after the strobe falls. A read releases the bus, holds the active-low read strobe low and latches the bus in the strobe's last cycle. Strobe width and turnaround length are parameters. Both flags pass through a two-stage synchronizer. After every strobe the sequencer waits long enough for a fresh sample of the flags to arrive before it starts another cycle. When both directions have work pending, the grants alternate.

The pad ring combines `bus_dout`, `bus_oe` and `bus_din` into the bidirectional pins.

Top module: `usb_byte_bridge`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset: `wr` is 0, `rd_n` is 1, `bus_oe` is 0, `tx_ready` is 0 and `rx_valid` is 0.
- R2: `bus_oe` is 1 only during a write cycle. It is 0 whenever `rd_n` is low, so the bus is released during every read.
- R3: A write is granted only while the synchronized `txe_n` is low. If `txe_n` stays high, `tx_ready` stays 0 and no write strobe occurs.
- R4: Each `wr` pulse is high for exactly STROBE_W cycles (default 3). `bus_dout` holds the accepted byte with `bus_oe` high from the cycle before `wr` rises until the cycle after it falls.
- R5: Each read holds `rd_n` low for exactly STROBE_W cycles. A read starts only while the synchronized `rxf_n` is low and no received byte is waiting in `rx_data`.
- R6: The byte on `bus_din` in the last low cycle of `rd_n` appears on `rx_data` with `rx_valid` high. Both hold unchanged until a cycle with `rx_ready` high.
- R7: When a write and a read are both eligible, the grant goes to the direction not served last. A continuous stream in both directions therefore gives strictly alternating strobes.
- R8: After any strobe ends, both strobes stay inactive for at least GAP_LEN = TURN_W + 2 cycles (default 3) before the next strobe starts. This lets the synchronized flags be sampled afresh.
- R9: Bytes leave the bridge on the bus in the order they were accepted on the transmit stream. Bytes read from the bus appear on the receive stream in the order they were read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to send to the host |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Byte accepted this cycle |
| rx_data | output | 8 | Byte received from the host |
| rx_valid | output | 1 | `rx_data` is offered |
| rx_ready | input | 1 | Consumer takes `rx_data` this cycle |
| bus_din | input | 8 | Data bus value seen at the pads |
| bus_dout | output | 8 | Data bus value driven during writes |
| bus_oe | output | 1 | Pad output enable for the data bus |
| wr | output | 1 | Write strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| txe_n | input | 1 | Device has room for a byte, active low |
| rxf_n | input | 1 | Device holds a received byte, active low |

## Verification
The bound checker watches several properties on every cycle: the exact strobe widths, the release of the bus during reads, and the data and enable being held across each write strobe. It also checks the turnaround gap between strobes, that every grant is backed by its synchronized flag, and the hold of an unaccepted received byte. Some behaviour can only be shown by the bench scenarios. Those scenarios cover byte ordering end to end through a device model, a write being held off while the space flag stays high, and reads stalling while the output stream is blocked. They also cover the strict alternation of strobes when both directions carry continuous traffic.

// File: rtl/ubb_pkg.sv
package ubb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSETUP,
    S_WPULSE,
    S_WHOLD,
    S_RPULSE,
    S_GAP
  } seq_state_t;

  // Pick the write direction: alternate when both want the bus.
  function automatic logic pick_write(input logic want_wr, input logic want_rd,
                                      input logic last_was_wr);
    if (want_wr && want_rd) return !last_was_wr;
    return want_wr;
  endfunction

  // Idle cycles after a strobe so the synchronized flags are fresh.
  function automatic int unsigned gap_cycles(input int unsigned turn_w,
                                             input int unsigned sync_stages);
    return turn_w + sync_stages;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ubb_sync.sv
module ubb_sync #(
  parameter int        WIDTH     = 2,
  parameter int        STAGES    = 2,
  parameter logic      RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ubb_arb.sv
module ubb_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic want_wr,
  input  logic want_rd,
  output logic gnt_wr,
  output logic gnt_rd
);
  import ubb_pkg::*;

  logic last_was_wr;
  logic choose_wr;

  assign choose_wr = pick_write(want_wr, want_rd, last_was_wr);
  assign gnt_wr    = in_idle && want_wr && choose_wr;
  assign gnt_rd    = in_idle && want_rd && !choose_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)      last_was_wr <= 1'b0;
    else if (gnt_wr) last_was_wr <= 1'b1;
    else if (gnt_rd) last_was_wr <= 1'b0;
  end
endmodule

// File: rtl/ubb_seq.sv
module ubb_seq #(
  parameter int DATA_W   = 8,
  parameter int STROBE_W = 3,
  parameter int GAP_LEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_wr,
  input  logic              gnt_rd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              rx_ready,
  output logic              in_idle,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              wr,
  output logic              rd_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_cap
);
  import ubb_pkg::*;

  localparam int MAXC  = max2(STROBE_W, GAP_LEN);
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_done;

  assign cnt_done = (cnt == '0);
  assign in_idle  = (state == S_IDLE);
  assign bus_oe   = (state == S_WSETUP) || (state == S_WPULSE) || (state == S_WHOLD);
  assign wr       = (state == S_WPULSE);
  assign rd_n     = (state != S_RPULSE);
  assign rx_cap   = (state == S_RPULSE) && cnt_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bus_dout <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (gnt_wr) begin
            bus_dout <= tx_data;
            state    <= S_WSETUP;
          end else if (gnt_rd) begin
            cnt   <= CNT_W'(STROBE_W - 1);
            state <= S_RPULSE;
          end
        end
        S_WSETUP: begin
          cnt   <= CNT_W'(STROBE_W - 1);
          state <= S_WPULSE;
        end
        S_WPULSE: begin
          if (cnt_done) state <= S_WHOLD;
          else          cnt   <= cnt - 1'b1;
        end
        S_WHOLD: begin
          cnt   <= CNT_W'(GAP_LEN - 1);
          state <= S_GAP;
        end
        S_RPULSE: begin
          if (cnt_done) begin
            rx_data  <= bus_din;
            rx_valid <= 1'b1;
            cnt      <= CNT_W'(GAP_LEN - 1);
            state    <= S_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_GAP: begin
          if (cnt_done) state <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_byte_bridge.sv
module usb_byte_bridge #(
  parameter int DATA_W      = 8,
  parameter int STROBE_W    = 3,
  parameter int TURN_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              wr,
  output logic              rd_n,
  input  logic              txe_n,
  input  logic              rxf_n
);
  import ubb_pkg::*;

  localparam int GAP_LEN = gap_cycles(TURN_W, SYNC_STAGES);

  logic [1:0] flags_s;
  logic       txe_s;
  logic       rxf_s;
  logic       in_idle;
  logic       want_wr;
  logic       want_rd;
  logic       gnt_wr;
  logic       gnt_rd;
  logic       rx_cap;

  ubb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({rxf_n, txe_n}),
    .q   (flags_s)
  );
  assign txe_s = flags_s[0];
  assign rxf_s = flags_s[1];

  assign want_wr = tx_valid && !txe_s;
  assign want_rd = !rxf_s && !rx_valid;

  ubb_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_idle (in_idle),
    .want_wr (want_wr),
    .want_rd (want_rd),
    .gnt_wr  (gnt_wr),
    .gnt_rd  (gnt_rd)
  );

  assign tx_ready = gnt_wr;

  ubb_seq #(.DATA_W(DATA_W), .STROBE_W(STROBE_W), .GAP_LEN(GAP_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt_wr   (gnt_wr),
    .gnt_rd   (gnt_rd),
    .tx_data  (tx_data),
    .bus_din  (bus_din),
    .rx_ready (rx_ready),
    .in_idle  (in_idle),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe),
    .wr       (wr),
    .rd_n     (rd_n),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_cap   (rx_cap)
  );
endmodule

// File: rtl/ubb_chk.sv
module ubb_chk #(
  parameter int DATA_W   = 8,
  parameter int STROBE_W = 3,
  parameter int GAP_LEN  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic              rd_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              gnt_wr,
  input logic              gnt_rd,
  input logic              txe_s,
  input logic              rxf_s
);
  logic [7:0] wr_run;
  logic [7:0] rd_run;
  logic [7:0] idle_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_run   <= '0;
      rd_run   <= '0;
      idle_run <= 8'(GAP_LEN);
    end else begin
      wr_run <= wr ? wr_run + 1'b1 : '0;
      rd_run <= !rd_n ? rd_run + 1'b1 : '0;
      if (wr || !rd_n)                idle_run <= '0;
      else if (idle_run < 8'(GAP_LEN)) idle_run <= idle_run + 1'b1;
    end
  end

  // R2
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);
  // R2
  oe_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> bus_oe);
  // R3
  wr_grant_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_wr |-> !txe_s);
  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr) |-> (wr_run == 8'(STROBE_W)));
  // R4
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> $stable(bus_dout) && bus_oe);
  // R5
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_run == 8'(STROBE_W)));
  // R5
  rd_grant_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_rd |-> !rxf_s && !rx_valid);
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_wr && gnt_rd));
  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr) || $fell(rd_n)) |-> (idle_run >= 8'(GAP_LEN)));
endmodule

bind usb_byte_bridge ubb_chk #(
  .DATA_W(DATA_W), .STROBE_W(STROBE_W), .GAP_LEN(GAP_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (wr),
  .rd_n     (rd_n),
  .bus_oe   (bus_oe),
  .bus_dout (bus_dout),
  .rx_data  (rx_data),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .gnt_wr   (gnt_wr),
  .gnt_rd   (gnt_rd),
  .txe_s    (txe_s),
  .rxf_s    (rxf_s)
);

// File: tb/sim_usb_byte_bridge.sv
`timescale 1ns/1ps
module sim_usb_byte_bridge;
  localparam int STROBE_W = 3;
  localparam int GAP      = 1 + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] bus_din = 8'hEE;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       wr;
  logic       rd_n;
  logic       txe_n = 1'b0;
  logic       rxf_n = 1'b1;

  always #2 clk = ~clk;

  usb_byte_bridge u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .wr(wr), .rd_n(rd_n), .txe_n(txe_n), .rxf_n(rxf_n)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  logic [7:0] chip_rxq[$];
  bit         kinds[$];
  bit   wr_prev = 0, rd_prev = 1, seen_strobe = 0;
  int   wr_len = 0, rd_len = 0, idle_cnt = 0, wr_starts = 0, rd_starts = 0;
  logic [7:0] hold_byte = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Device model and scoreboard monitor, all on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr && !wr_prev) begin
        wr_starts++;
        kinds.push_back(1'b1);
        if (seen_strobe) check(idle_cnt >= GAP, "R8 gap before write", idle_cnt, GAP);
        seen_strobe = 1;
        idle_cnt = 0;
        if (exp_tx.size() == 0) check(0, "R9 unexpected write", bus_dout, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          check(bus_dout == e, "R9 write byte", bus_dout, e);
        end
        hold_byte = bus_dout;
        wr_len = 1;
      end else if (wr) begin
        wr_len++;
        if (bus_dout != hold_byte || !bus_oe)
          check(0, "R4 write data hold", bus_dout, hold_byte);
      end
      if (!wr && wr_prev) begin
        check(wr_len == STROBE_W, "R4 write width", wr_len, STROBE_W);
        check(bus_oe && bus_dout == hold_byte, "R4 hold after write", bus_dout, hold_byte);
      end
      if (!rd_n && rd_prev) begin
        rd_starts++;
        kinds.push_back(1'b0);
        if (seen_strobe) check(idle_cnt >= GAP, "R8 gap before read", idle_cnt, GAP);
        seen_strobe = 1;
        idle_cnt = 0;
        check(chip_rxq.size() > 0, "R5 read needs data", chip_rxq.size(), 1);
        check(bus_oe == 1'b0, "R2 bus released in read", bus_oe, 0);
        rd_len = 1;
      end else if (!rd_n) rd_len++;
      if (rd_n && !rd_prev) begin
        check(rd_len == STROBE_W, "R5 read width", rd_len, STROBE_W);
        if (chip_rxq.size() > 0) void'(chip_rxq.pop_front());
      end
      if (!wr && rd_n) idle_cnt++;
      if (rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) check(0, "R6 unexpected rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R6 R9 rx byte", rx_data, e);
        end
      end
    end
    wr_prev = wr;
    rd_prev = rd_n;
    rxf_n   = (chip_rxq.size() == 0);
    bus_din = (!rd_n && chip_rxq.size() > 0) ? chip_rxq[0] : 8'hEE;
  end

  task automatic wait_accept();
    forever begin
      #1;
      if (tx_ready) begin
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_tx.push_back(b);
    tx_data  = b;
    tx_valid = 1'b1;
    wait_accept();
  endtask

  task automatic load_rx(input logic [7:0] b);
    chip_rxq.push_back(b);
    exp_rx.push_back(b);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R1 reset state, with a byte offered during reset
    tx_valid = 1'b1;
    tx_data  = 8'h5A;
    repeat (4) @(negedge clk);
    check(!wr && rd_n && !bus_oe, "R1 strobes idle in reset", {wr, rd_n, bus_oe}, 3'b010);
    check(!tx_ready && !rx_valid, "R1 streams idle in reset", {tx_ready, rx_valid}, 0);
    tx_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr && rd_n && !bus_oe && !rx_valid, "R1 idle after reset",
          {wr, rd_n, bus_oe, rx_valid}, 4'b0100);

    // R3: space flag high holds off a pending write
    txe_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_tx.push_back(8'hA5);
    tx_data  = 8'hA5;
    tx_valid = 1'b1;
    begin
      int seen_ready = 0;
      repeat (30) begin
        #1; if (tx_ready) seen_ready++;
        @(negedge clk);
      end
      check(seen_ready == 0, "R3 no accept while full", seen_ready, 0);
      check(wr_starts == 0, "R3 no write strobe while full", wr_starts, 0);
    end
    txe_n = 1'b0;
    wait_accept();

    // R4 R9: back-to-back writes
    send_tx(8'h11);
    send_tx(8'h22);
    send_tx(8'h33);
    repeat (20) @(negedge clk);
    check(wr_starts == 4, "R9 write count", wr_starts, 4);

    // R5 R6: reads stall while output stream is blocked
    rx_ready = 1'b0;
    load_rx(8'hC3);
    load_rx(8'h3C);
    repeat (20) @(negedge clk);
    check(rx_valid && rx_data == 8'hC3, "R6 first byte presented", rx_data, 8'hC3);
    repeat (20) @(negedge clk);
    check(rx_valid && rx_data == 8'hC3, "R6 byte held while stalled", rx_data, 8'hC3);
    check(rd_starts == 1, "R5 no read while buffer full", rd_starts, 1);
    rx_ready = 1'b1;
    repeat (40) @(negedge clk);
    check(rd_starts == 2, "R5 second read after drain", rd_starts, 2);

    // R7: both directions busy -> strict alternation
    kinds.delete();
    for (int i = 0; i < 4; i++) load_rx(8'h80 + 8'(i));
    for (int i = 0; i < 4; i++) send_tx(8'h40 + 8'(i));
    repeat (60) @(negedge clk);
    check(kinds.size() == 8, "R7 strobe count", kinds.size(), 8);
    begin
      int flips = 0;
      for (int i = 1; i < kinds.size(); i++) if (kinds[i] != kinds[i-1]) flips++;
      check(flips == 7, "R7 alternating strobes", flips, 7);
    end

    check(exp_tx.size() == 0, "R9 all writes seen", exp_tx.size(), 0);
    check(exp_rx.size() == 0, "R9 all reads delivered", exp_rx.size(), 0);
    summary();
    $finish;
  end
endmodule